// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader with Address-Width Probe

This block is a hardware master for a three-wire serial EEPROM. It drives chip select, serial clock and serial data-in, and samples the serial data-out line. A host presents a word address, an address width and a one-cycle start pulse. The block then frames a single read command on the serial lines and returns the 16-bit word. A done strobe marks the end of the transaction.

The address-field width of the attached EEPROM is not fixed. A probe transaction finds it at run time. In a probe the block sends the read command with an all-zero address, one bit per clock pulse. After each address pulse it watches the data-out line for the dummy zero that the EEPROM drives once it holds a complete address. The number of address bits sent up to that point is the width. The block reports it on a width output and shifts the data word through without keeping it. If no dummy zero shows up within the supported width range, the transaction is cut short and an error flag is raised.

Serial clock high and low times are parameters counted in system clock cycles. A host can therefore match any EEPROM speed grade without other changes.

Top module: `mw_word_reader`

## Requirements
- R1: While reset is high and on the cycle after it is released, cs_o, sk_o, di_o, busy_o, done_o and err_o are 0, data_o is 0, and width_o equals AW_MAX (8 by default).
- R2: A start pulse taken while idle raises cs_o on the next cycle. The first three bits presented on di_o at sk_o rising edges are 1, 1, 0 in that order: the start bit followed by the read opcode.
- R3: While cs_o is high, every sk_o high period lasts exactly SK_HI cycles and every sk_o low period lasts exactly SK_LO cycles. This includes the low lead-in between cs_o rising and the first sk_o rise. di_o does not change while sk_o is high.
- R4: In a normal read (probe_i = 0), the address field holds the low W bits of addr_i, most significant first. W is width_i clamped to the range 6 to 8. The cs_o high time is SK_LO + (3 + W + 16) * (SK_HI + SK_LO) cycles.
- R5: The 16 data bits are sampled from do_i at the end of each data sk_o high period, most significant first. After a normal read completes, data_o holds the word.
- R6: In a probe (probe_i = 1), all address bits are 0. do_i is sampled at the end of each address bit's low period. The first sample that reads 0 after N bits, with 6 <= N <= 8, ends the address field. width_o becomes N, 16 data pulses follow, and data_o keeps its previous value.
- R7: A probe fails if do_i reads 0 after fewer than 6 bits, or is still 1 after 8 bits. The transaction then ends right after that bit's low period, with no data pulses, err_o is 1 and width_o is unchanged. The next accepted start clears err_o.
- R8: done_o is high for exactly one cycle, the cycle in which cs_o first reads low. busy_o is high from the cycle after an accepted start until the gap after that transaction has ended.
- R9: A start pulse that arrives while busy_o is high has no effect. The running transaction keeps its address and length, and no further transaction follows it.
- R10: While cs_o is low, sk_o and di_o are low. Between two transactions cs_o stays low for at least SK_LO cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a transaction |
| probe_i | input | 1 | 1 = width probe, 0 = normal word read |
| addr_i | input | AW_MAX | Word address, right-aligned |
| width_i | input | clog2(AW_MAX+1) | Address width for a normal read, clamped to 6..8 |
| busy_o | output | 1 | Transaction or inter-transaction gap in progress |
| done_o | output | 1 | One-cycle end-of-transaction strobe |
| err_o | output | 1 | Last probe found no valid dummy zero |
| data_o | output | 16 | Last word returned by a normal read |
| width_o | output | clog2(AW_MAX+1) | Address width found by the last successful probe |
| cs_o | output | 1 | EEPROM chip select |
| sk_o | output | 1 | EEPROM serial clock |
| di_o | output | 1 | Serial data to the EEPROM |
| do_i | input | 1 | Serial data from the EEPROM |

## Verification
The hardest situation to reach from the ports is the failing probe, because a real EEPROM always answers with its dummy zero at its own fixed width. The bench's behavioural EEPROM takes its address width as a variable that can be set per transaction. Setting it to 4 makes the zero arrive too early. Setting it to 9 means the zero never arrives within the 8-bit limit. The early cut-off and the error flag are then checked against the expected shortened chip-select time. Start pulses injected in the middle of a running read cover the ignore-while-busy case. Width values outside 6..8 cover the clamp.

// File: rtl/mw_reader_pkg.sv
package mw_reader_pkg;
  localparam int OPC_BITS = 3;
  localparam logic [OPC_BITS-1:0] RD_OPCODE = 3'b110;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_HIGH,
    PH_LOW,
    PH_GAP
  } phase_t;

  typedef enum logic [1:0] {
    SEC_CMD,
    SEC_ADDR,
    SEC_DATA
  } sect_t;
endpackage

// File: rtl/mw_sk_timer.sv
module mw_sk_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - CW'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign last_o = (cnt_q == '0);

  // R3
  timer_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && len_i > CW'(1)) |=> !last_o);
endmodule

// File: rtl/mw_addr_align.sv
module mw_addr_align
  import mw_reader_pkg::*;
#(
  parameter int AW_MIN = 6,
  parameter int AW_MAX = 8,
  parameter int WW     = 4,
  localparam int TXW   = OPC_BITS + AW_MAX
) (
  input  logic [AW_MAX-1:0] addr_i,
  input  logic [WW-1:0]     width_i,
  input  logic              probe_i,
  output logic [WW-1:0]     eff_w_o,
  output logic [TXW-1:0]    tx_o
);
  logic [WW-1:0]     shamt;
  logic [AW_MAX-1:0] aligned;

  always_comb begin
    if (width_i < WW'(AW_MIN)) begin
      eff_w_o = WW'(AW_MIN);
    end else if (width_i > WW'(AW_MAX)) begin
      eff_w_o = WW'(AW_MAX);
    end else begin
      eff_w_o = width_i;
    end
    shamt   = WW'(AW_MAX) - eff_w_o;
    aligned = addr_i << shamt;
    tx_o    = {RD_OPCODE, (probe_i ? '0 : aligned)};
  end

  // R4
  always_comb begin
    clamp_range_chk: assert (eff_w_o >= WW'(AW_MIN) && eff_w_o <= WW'(AW_MAX));
  end
endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [DW-1:0] word_o
);
  logic [DW-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (shift_i) begin
      sr_q <= {sr_q[DW-2:0], bit_i};
    end
  end

  assign word_o = sr_q;
endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_reader_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW_MIN = 6,
  parameter int AW_MAX = 8,
  parameter int SK_HI  = 4,
  parameter int SK_LO  = 4,
  parameter int WW     = 4,
  parameter int CW     = 3,
  localparam int TXW   = OPC_BITS + AW_MAX,
  localparam int CNTW  = $clog2(((DW > AW_MAX) ? DW : AW_MAX) + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          probe_i,
  input  logic [WW-1:0] eff_w_i,
  input  logic [TXW-1:0] tx_i,
  input  logic          do_i,
  input  logic          tmr_last_i,
  input  logic [DW-1:0] rx_word_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_len_o,
  output logic          rx_shift_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] data_o,
  output logic [WW-1:0] width_o,
  output logic          cs_o,
  output logic          sk_o,
  output logic          di_o
);
  phase_t         phase_q;
  sect_t          sect_q;
  logic [CNTW-1:0] bcnt_q;
  logic [TXW-1:0] tx_q;
  logic           probe_q;
  logic [WW-1:0]  w_q;
  logic           cs_q, sk_q, di_q, busy_q, done_q, err_q;
  logic [DW-1:0]  data_q;
  logic [WW-1:0]  width_q;

  logic [CNTW-1:0] addr_n;
  logic           probe_bad, addr_last, data_last, end_now, accept;

  always_comb begin
    addr_n    = bcnt_q + CNTW'(1);
    probe_bad = probe_q && (do_i ? (addr_n == CNTW'(AW_MAX))
                                 : (addr_n < CNTW'(AW_MIN)));
    addr_last = probe_q ? !do_i : (addr_n == CNTW'(w_q));
    data_last = (bcnt_q == CNTW'(DW-1));
    end_now   = (phase_q == PH_LOW) && tmr_last_i &&
                (((sect_q == SEC_ADDR) && probe_bad) ||
                 ((sect_q == SEC_DATA) && data_last));
    accept    = (phase_q == PH_IDLE) && start_i;
    tmr_load_o = accept ||
                 (tmr_last_i && ((phase_q == PH_LEAD) || (phase_q == PH_HIGH) ||
                                 (phase_q == PH_LOW)));
    tmr_len_o  = ((phase_q == PH_IDLE) || (phase_q == PH_HIGH) || end_now)
                 ? CW'(SK_LO) : CW'(SK_HI);
    rx_shift_o = (phase_q == PH_HIGH) && tmr_last_i && (sect_q == SEC_DATA);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      sect_q  <= SEC_CMD;
      bcnt_q  <= '0;
      tx_q    <= '0;
      probe_q <= 1'b0;
      w_q     <= WW'(AW_MAX);
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      di_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= '0;
      width_q <= WW'(AW_MAX);
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            busy_q  <= 1'b1;
            cs_q    <= 1'b1;
            sk_q    <= 1'b0;
            tx_q    <= tx_i;
            di_q    <= tx_i[TXW-1];
            probe_q <= probe_i;
            w_q     <= eff_w_i;
            err_q   <= 1'b0;
            sect_q  <= SEC_CMD;
            bcnt_q  <= '0;
            phase_q <= PH_LEAD;
          end
        end
        PH_LEAD: begin
          if (tmr_last_i) begin
            sk_q    <= 1'b1;
            phase_q <= PH_HIGH;
          end
        end
        PH_HIGH: begin
          if (tmr_last_i) begin
            sk_q    <= 1'b0;
            tx_q    <= {tx_q[TXW-2:0], 1'b0};
            di_q    <= tx_q[TXW-2];
            phase_q <= PH_LOW;
          end
        end
        PH_LOW: begin
          if (tmr_last_i) begin
            if (end_now) begin
              cs_q    <= 1'b0;
              di_q    <= 1'b0;
              done_q  <= 1'b1;
              phase_q <= PH_GAP;
              if (sect_q == SEC_ADDR) begin
                err_q <= 1'b1;
              end else if (!probe_q) begin
                data_q <= rx_word_i;
              end
            end else begin
              sk_q    <= 1'b1;
              phase_q <= PH_HIGH;
              unique case (sect_q)
                SEC_CMD: begin
                  if (bcnt_q == CNTW'(OPC_BITS-1)) begin
                    sect_q <= SEC_ADDR;
                    bcnt_q <= '0;
                  end else begin
                    bcnt_q <= addr_n;
                  end
                end
                SEC_ADDR: begin
                  if (addr_last) begin
                    if (probe_q) begin
                      width_q <= WW'(addr_n);
                    end
                    sect_q <= SEC_DATA;
                    bcnt_q <= '0;
                  end else begin
                    bcnt_q <= addr_n;
                  end
                end
                default: begin
                  bcnt_q <= addr_n;
                end
              endcase
            end
          end
        end
        PH_GAP: begin
          if (tmr_last_i) begin
            busy_q  <= 1'b0;
            phase_q <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign data_o  = data_q;
  assign width_o = width_q;
  assign cs_o    = cs_q;
  assign sk_o    = sk_q;
  assign di_o    = di_q;

  // R10
  idle_lines_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_q |-> (!sk_q && !di_q));

  // R3
  sk_edge_on_timer_chk: assert property (@(posedge clk) disable iff (rst)
    (sk_q != $past(sk_q)) |-> $past(tmr_last_i));

  // R3
  di_stable_high_chk: assert property (@(posedge clk) disable iff (rst)
    (sk_q && $past(sk_q)) |-> $stable(di_q));

  // R8
  done_at_cs_fall_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!cs_q && $past(cs_q)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> done_q);

  // R6
  width_range_chk: assert property (@(posedge clk) disable iff (rst)
    (width_q >= WW'(AW_MIN)) && (width_q <= WW'(AW_MAX)));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done_q && phase_q != PH_GAP) |=> busy_q);
endmodule

// File: rtl/mw_word_reader.sv
module mw_word_reader
  import mw_reader_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW_MIN = 6,
  parameter int AW_MAX = 8,
  parameter int SK_HI  = 4,
  parameter int SK_LO  = 4,
  localparam int WW    = $clog2(AW_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              probe_i,
  input  logic [AW_MAX-1:0] addr_i,
  input  logic [WW-1:0]     width_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DW-1:0]     data_o,
  output logic [WW-1:0]     width_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  input  logic              do_i
);
  localparam int CW  = $clog2(((SK_HI > SK_LO) ? SK_HI : SK_LO) + 1);
  localparam int TXW = OPC_BITS + AW_MAX;

  logic [WW-1:0]  eff_w;
  logic [TXW-1:0] tx_bits;
  logic           tmr_load, tmr_last, rx_shift;
  logic [CW-1:0]  tmr_len;
  logic [DW-1:0]  rx_word;

  mw_addr_align #(.AW_MIN(AW_MIN), .AW_MAX(AW_MAX), .WW(WW)) align_i (
    .addr_i(addr_i), .width_i(width_i), .probe_i(probe_i),
    .eff_w_o(eff_w), .tx_o(tx_bits)
  );

  mw_sk_timer #(.CW(CW)) timer_i (
    .clk(clk), .rst(rst), .load_i(tmr_load), .len_i(tmr_len), .last_o(tmr_last)
  );

  mw_rx_shift #(.DW(DW)) rx_i (
    .clk(clk), .rst(rst), .shift_i(rx_shift), .bit_i(do_i), .word_o(rx_word)
  );

  mw_seq #(
    .DW(DW), .AW_MIN(AW_MIN), .AW_MAX(AW_MAX), .SK_HI(SK_HI), .SK_LO(SK_LO),
    .WW(WW), .CW(CW)
  ) seq_i (
    .clk(clk), .rst(rst), .start_i(start_i), .probe_i(probe_i),
    .eff_w_i(eff_w), .tx_i(tx_bits), .do_i(do_i), .tmr_last_i(tmr_last),
    .rx_word_i(rx_word), .tmr_load_o(tmr_load), .tmr_len_o(tmr_len),
    .rx_shift_o(rx_shift), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .data_o(data_o), .width_o(width_o), .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o)
  );
endmodule

// File: tb/mw_word_reader_tb_top.sv
module mw_word_reader_tb_top;
  localparam int HI = 3;
  localparam int LO = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, probe_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [3:0] width_i = 4'd8;
  logic busy_o, done_o, err_o, cs_o, sk_o, di_o;
  logic [15:0] data_o;
  logic [3:0] width_o;
  logic do_w = 1'b1;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  mw_word_reader #(.SK_HI(HI), .SK_LO(LO)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .probe_i(probe_i),
    .addr_i(addr_i), .width_i(width_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .data_o(data_o), .width_o(width_o), .cs_o(cs_o),
    .sk_o(sk_o), .di_o(di_o), .do_i(do_w)
  );

  function automatic logic [15:0] eep_word(input int a);
    return 16'(a * 40503 + 16'h1D3C) ^ (16'(a) << 7);
  endfunction

  function automatic int cs_len(input int nbits);
    return LO + nbits * (HI + LO);
  endfunction

  function automatic int clampw(input int w);
    return (w < 6) ? 6 : (w > 8) ? 8 : w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural EEPROM with run-time address width
  int m_aw = 8, m_state = 0, m_cnt = 0;
  logic [1:0] m_op;
  logic m_first;
  logic [15:0] m_addr, m_word;
  always @(posedge sk_o or posedge cs_o) begin
    if (!sk_o) begin
      m_state = 0; m_cnt = 0; m_op = 0; m_addr = 0; m_first = 1'bx; do_w = 1'b1;
    end else begin
      case (m_state)
        0: begin m_first = di_o; if (di_o) m_state = 1; end
        1: begin
          m_op = {m_op[0], di_o}; m_cnt++;
          if (m_cnt == 2) begin m_state = 2; m_cnt = 0; end
        end
        2: begin
          m_addr = {m_addr[14:0], di_o}; m_cnt++;
          if (m_cnt == m_aw) begin
            do_w = 1'b0; m_word = eep_word(int'(m_addr)); m_state = 3; m_cnt = 0;
          end
        end
        3: begin
          do_w = m_word[15 - m_cnt]; m_cnt++;
          if (m_cnt == 16) m_state = 4;
        end
        default: ;
      endcase
    end
  end

  // protocol monitor
  int hi_run = 0, lo_run = 0, cs_run = 0, gap_run = 0, last_cs_len = 0;
  int v_hi = 0, v_lo = 0, v_di = 0, v_idle = 0, v_gap = 0;
  bit prev_cs = 0, prev_sk = 0, prev_di = 0, seen_cs = 0;
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (cs_o) begin
        if (!prev_cs && seen_cs && gap_run < LO) v_gap++;
        cs_run++;
        if (sk_o) begin
          hi_run++;
          if (prev_sk && di_o != prev_di) v_di++;
          if (!prev_sk) begin if (lo_run != LO) v_lo++; lo_run = 0; end
        end else begin
          lo_run++;
          if (prev_sk) begin if (hi_run != HI) v_hi++; hi_run = 0; end
        end
      end else begin
        if (prev_cs) begin
          last_cs_len = cs_run; cs_run = 0; gap_run = 0; lo_run = 0; hi_run = 0;
          seen_cs = 1;
        end
        gap_run++;
        if (sk_o || di_o) v_idle++;
      end
      prev_cs = cs_o; prev_sk = sk_o; prev_di = di_o;
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  logic [15:0] last_data = 16'h0;

  // launch a transaction and wait until done; returns nothing, checks timing
  task automatic run_txn(input bit probe, input logic [7:0] addr, input int w,
                         input int exp_bits, input bit inject);
    while (busy_o) @(negedge clk);
    start_i = 1'b1; probe_i = probe; addr_i = addr; width_i = 4'(w);
    @(negedge clk);
    start_i = 1'b0;
    check(cs_o && busy_o, "R2", {cs_o, busy_o}, 2'b11);
    if (inject) begin
      repeat (30) @(negedge clk);
      start_i = 1'b1; probe_i = ~probe; addr_i = ~addr; width_i = 4'd6;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    check(!cs_o && busy_o, "R8", {cs_o, busy_o}, 2'b01);
    @(negedge clk);
    check(!done_o, "R8", done_o, 0);
    check(last_cs_len == cs_len(exp_bits), probe ? "R6" : "R4", last_cs_len,
          cs_len(exp_bits));
    check(m_first == 1'b1 && m_op == 2'b10, "R2", {m_first, m_op}, 3'b110);
  endtask

  task automatic normal_read(input logic [7:0] addr, input int w, input bit inject);
    int ew = clampw(w);
    logic [15:0] a = 16'(addr) & 16'((1 << ew) - 1);
    m_aw = ew;
    run_txn(1'b0, addr, w, 3 + ew + 16, inject);
    check(m_addr == a, "R4", m_addr, a);
    check(data_o == eep_word(int'(a)), "R5", data_o, eep_word(int'(a)));
    check(!err_o, "R7", err_o, 0);
    last_data = data_o;
  endtask

  task automatic probe_ok(input int aw);
    m_aw = aw;
    run_txn(1'b1, 8'hA5, 8, 3 + aw + 16, 1'b0);
    check(width_o == 4'(aw), "R6", width_o, aw);
    check(m_addr == 16'h0, "R6", m_addr, 0);
    check(data_o == last_data, "R6", data_o, last_data);
    check(!err_o, "R6", err_o, 0);
  endtask

  task automatic probe_bad(input int aw, input int sent);
    logic [3:0] wprev = width_o;
    m_aw = aw;
    run_txn(1'b1, 8'h00, 8, 3 + sent, 1'b0);
    check(err_o, "R7", err_o, 1);
    check(width_o == wprev, "R7", width_o, wprev);
    check(data_o == last_data, "R7", data_o, last_data);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!cs_o && !sk_o && !di_o && !busy_o && !done_o && !err_o, "R1",
          {cs_o, sk_o, di_o, busy_o, done_o, err_o}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(!cs_o && !busy_o && !err_o && data_o == 0, "R1", {cs_o, busy_o, err_o}, 0);
    check(width_o == 4'd8, "R1", width_o, 8);

    // R6 probes at each legal width
    probe_ok(6); probe_ok(8); probe_ok(7);
    // R4 R5 directed corners
    normal_read(8'hFF, 8, 1'b0);
    normal_read(8'h00, 6, 1'b0);
    normal_read(8'hC1, 7, 1'b0);
    // R4 width clamp below and above
    normal_read(8'hFF, 2, 1'b0);
    normal_read(8'h5A, 15, 1'b0);
    // R7 early zero and missing zero
    probe_bad(4, 4);
    normal_read(8'h3C, 8, 1'b0);
    probe_bad(9, 8);
    probe_ok(8);
    // R9 start while busy ignored
    normal_read(8'h6E, 7, 1'b1);
    check(width_o == 4'd8, "R9", width_o, 8);
    repeat (LO + 40) begin
      @(negedge clk);
      check(!cs_o, "R9", cs_o, 0);
    end
    // random reads
    for (int i = 0; i < 24; i++) begin
      normal_read(8'($urandom()), 6 + int'($urandom() % 3), 1'b0);
    end
    repeat (20) @(negedge clk);
    check(v_hi == 0 && v_lo == 0 && v_di == 0, "R3", v_hi + v_lo + v_di, 0);
    check(v_idle == 0 && v_gap == 0, "R10", v_idle + v_gap, 0);
    finish_run();
  end
endmodule